// File: doc/BRIEF.md
# Prescaled Modulo Timer

A 16-bit up-counting timer controlled through a small memory-mapped register bus. The counter starts from a programmable start value, climbs one step per tick until it equals a programmable limit, and on the tick after that it reloads the start value. Each reload sets a sticky overflow flag. While the interrupt enable is on, that flag drives a level interrupt. A power-of-two prescaler divides the system clock to form the tick.

Software starts the timer by selecting the system clock in the control register. It stops the timer by writing zero to that field. The limit and start values are written into shadow copies. These reach the live comparison only while the counter is stopped, so a running count is never disturbed. Writing anything to the counter register reloads the start value. To clear the overflow flag, software reads the control register, sees the flag set, and writes the register back with that bit at zero.

Top module: `pmt_timer`

## Requirements
- R1: After reset the control register and counter read 0, the limit reads 0x0000FFFF, the start value reads 0, and `irq_o` is low.
- R2: Register offsets are control 0x00, counter 0x04, limit 0x08 and start value 0x4C. Control fields: bits [2:0] prescale exponent, bits [4:3] clock source, bit 6 interrupt enable, bit 7 overflow flag.
- R3: On each tick the counter increments. On the tick after it equals the live limit, it reloads the live start value instead, so one period is limit - start + 1 ticks.
- R4: The overflow flag is set on the clock edge at which the counter reloads from the limit to the start value.
- R5: A write of any data to the counter register loads the live start value; the written data is ignored.
- R6: Limit and start writes go into shadow registers, and reads return the shadow values. A shadow value is copied to the live register only while the clock source field is 0. While the source is nonzero, the live values stay unchanged.
- R7: With prescale exponent p, a tick occurs every 2^p clock cycles. The first tick comes 2^p cycles after the counter starts running.
- R8: Clock source value 1 runs the counter. Values 0, 2 and 3 hold it.
- R9: Writing 1 to bit 7 has no effect. Writing 0 to bit 7 clears the flag only if a control read returned the flag set after the previous control write. A wrap in the same cycle keeps the flag set.
- R10: `irq_o` is high exactly while both the overflow flag and the interrupt enable are 1.
- R11: Unused bits read 0 and register values keep only the low 16 bits. Writes to other offsets change nothing, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed register |
| irq_o | output | 1 | Level overflow interrupt |

## Verification
The bench builds the block with its default 16-bit counter and 3-bit prescale field. Small limit and start values keep each wrap within a few cycles. Exponent 2 makes the tick spacing visible. Loading a start value just below 0xFFFF reaches the top-of-range wrap without waiting out a full free-running period. Each wrap is timed on the interrupt pin to the exact cycle, which exposes an off-by-one in the compare, the reload, the shadow copy or the prescaler.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

    localparam int unsigned PS_W = 3;

    typedef enum logic [1:0] {
        CS_OFF  = 2'd0,
        CS_SYS  = 2'd1,
        CS_RSV2 = 2'd2,
        CS_RSV3 = 2'd3
    } clksrc_e;

    typedef struct packed {
        logic            flag;
        logic            ie;
        clksrc_e         src;
        logic [PS_W-1:0] ps;
    } ctrl_t;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_CNT  = 8'h04;
    localparam logic [7:0] OFS_LIM  = 8'h08;
    localparam logic [7:0] OFS_INIT = 8'h4C;

endpackage

// File: rtl/pmt_prescaler.sv
module pmt_prescaler #(
    parameter int unsigned PS_W = 3
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            run_i,
    input  logic [PS_W-1:0] ps_i,
    output logic            tick_o
);
    localparam int unsigned DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask   = ~({DIV_W{1'b1}} << ps_i);
        tick_o = run_i && ((div_q & mask) == mask);
        div_d  = run_i ? div_q + 1'b1 : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) div_q <= '0;
        else         div_q <= div_d;
    end

    AST_NO_TICK_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(run_i) |-> (div_q == '0)); // R8

endmodule

// File: rtl/pmt_counter.sv
module pmt_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] init_i,
    input  logic [CNT_W-1:0] lim_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cstate_t;

    cstate_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        wrap_o = tick_i && !load_i && (st_q.cnt == lim_i);
        if (load_i)      st_d.cnt = init_i;
        else if (wrap_o) st_d.cnt = init_i;
        else if (tick_i) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    AST_WRAP_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_o |=> (st_q.cnt == $past(init_i))); // R3
    AST_LOAD_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (st_q.cnt == $past(init_i))); // R5
    AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !load_i) |=> $stable(st_q.cnt)); // R8

endmodule

// File: rtl/pmt_timer.sv
module pmt_timer
    import pmt_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    localparam int unsigned CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t            ctrl;
        logic             armed;
        logic [CNT_W-1:0] lim_buf;
        logic [CNT_W-1:0] lim_act;
        logic [CNT_W-1:0] init_buf;
        logic [CNT_W-1:0] init_act;
    } tstate_t;

    tstate_t st_d, st_q;

    logic             wr_en, rd_en;
    logic             hit_ctrl, hit_cnt, hit_lim, hit_init;
    logic             tick, wrap, load;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        wr_en    = bus_sel_i && bus_wr_i;
        rd_en    = bus_sel_i && !bus_wr_i;
        hit_ctrl = (bus_addr_i == ADDR_W'(OFS_CTRL));
        hit_cnt  = (bus_addr_i == ADDR_W'(OFS_CNT));
        hit_lim  = (bus_addr_i == ADDR_W'(OFS_LIM));
        hit_init = (bus_addr_i == ADDR_W'(OFS_INIT));
        load     = wr_en && hit_cnt;
    end

    pmt_prescaler #(.PS_W(PS_W)) u_presc (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (st_q.ctrl.src == CS_SYS),
        .ps_i   (st_q.ctrl.ps),
        .tick_o (tick)
    );

    pmt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tick),
        .load_i (load),
        .init_i (st_q.init_act),
        .lim_i  (st_q.lim_act),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en && hit_ctrl) begin
            st_d.ctrl.ps  = bus_wdata_i[PS_W-1:0];
            st_d.ctrl.src = clksrc_e'(bus_wdata_i[4:3]);
            st_d.ctrl.ie  = bus_wdata_i[6];
            st_d.armed    = 1'b0;
            if (!bus_wdata_i[7] && st_q.armed) st_d.ctrl.flag = 1'b0;
        end
        if (rd_en && hit_ctrl && st_q.ctrl.flag) st_d.armed = 1'b1;
        if (wrap) st_d.ctrl.flag = 1'b1;
        if (wr_en && hit_lim)  st_d.lim_buf  = bus_wdata_i[CNT_W-1:0];
        if (wr_en && hit_init) st_d.init_buf = bus_wdata_i[CNT_W-1:0];
        if (st_q.ctrl.src == CS_OFF) begin
            st_d.lim_act  = st_q.lim_buf;
            st_d.init_act = st_q.init_buf;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q          <= '0;
            st_q.lim_buf  <= '1;
            st_q.lim_act  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        if (hit_ctrl) begin
            bus_rdata_o[CTRL_W-1+1:0] = {st_q.ctrl.flag, st_q.ctrl.ie, 1'b0,
                                         st_q.ctrl.src, st_q.ctrl.ps};
        end else if (hit_cnt) begin
            bus_rdata_o[CNT_W-1:0] = cnt;
        end else if (hit_lim) begin
            bus_rdata_o[CNT_W-1:0] = st_q.lim_buf;
        end else if (hit_init) begin
            bus_rdata_o[CNT_W-1:0] = st_q.init_buf;
        end
    end

    assign irq_o = st_q.ctrl.flag & st_q.ctrl.ie;

    AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap |=> st_q.ctrl.flag); // R4
    AST_ACT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ctrl.src != CS_OFF) |=> ($stable(st_q.lim_act) && $stable(st_q.init_act))); // R6
    AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(st_q.ctrl.flag) |-> $past(st_q.armed)); // R9
    AST_IRQ_FOLLOWS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> (st_q.ctrl.ie && st_q.ctrl.flag)); // R10

endmodule

// File: tb/sim_pmt_timer.sv
module sim_pmt_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    localparam logic [7:0] A_CTRL = 8'h00, A_CNT = 8'h04, A_LIM = 8'h08, A_INIT = 8'h4C;

    always #10 clk = ~clk;

    pmt_timer u0 (
        .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [7:0] a, input logic [31:0] d);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic rreg(input logic [7:0] a, output logic [31:0] d);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_wrap(input string req, input int k);
        for (int i = 1; i <= k; i++) begin
            @(negedge clk);
            if (i == k - 1) chk({req, " irq before wrap"}, {31'd0, irq}, 32'd0);
            if (i == k)     chk({req, " irq at wrap"}, {31'd0, irq}, 32'd1);
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rreg(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
        rreg(A_CNT, v);  chk("R1 count", v, 32'h0);
        rreg(A_LIM, v);  chk("R1 limit", v, 32'h0000FFFF);
        rreg(A_INIT, v); chk("R1 start", v, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_count();
        logic [31:0] v;
        wreg(A_INIT, 32'd3); wreg(A_LIM, 32'd7); idle(1);
        wreg(A_CNT, 32'hBEEF);
        rreg(A_CNT, v); chk("R5 reload", v, 32'd3);
        wreg(A_CTRL, 32'h48);
        wait_wrap("R3 R4", 5);
        wreg(A_CTRL, 32'h40);
        rreg(A_CNT, v); chk("R3 after reload", v, 32'd4);
        rreg(A_CTRL, v); chk("R9 flag kept without read", v, 32'hC0);
        wreg(A_CTRL, 32'h40);
        rreg(A_CTRL, v); chk("R9 flag cleared", v, 32'h40);
        chk("R10 irq low", {31'd0, irq}, 32'd0);
        wreg(A_CTRL, 32'hC0);
        rreg(A_CTRL, v); chk("R9 write one ignored", v, 32'h40);
        wreg(A_CNT, 32'h1234);
        rreg(A_CNT, v); chk("R5 data ignored", v, 32'd3);
    endtask

    task automatic t_shadow();
        logic [31:0] v;
        wreg(A_CTRL, 32'h48);
        wreg(A_LIM, 32'd2);
        wreg(A_CNT, 32'd0);
        wait_wrap("R6 live limit kept", 5);
        wreg(A_CTRL, 32'h00);
        rreg(A_LIM, v); chk("R6 shadow read", v, 32'd2);
        rreg(A_CTRL, v); chk("R2 flag bit", v, 32'h80);
        wreg(A_CTRL, 32'h00);
        wreg(A_INIT, 32'd0); idle(2);
        wreg(A_CNT, 32'd0); idle(1);
        wreg(A_CTRL, 32'h48);
        wait_wrap("R6 copied while stopped", 3);
        wreg(A_CTRL, 32'h00);
        rreg(A_CTRL, v); wreg(A_CTRL, 32'h00);
    endtask

    task automatic t_prescale();
        logic [31:0] v;
        wreg(A_CNT, 32'd0);
        wreg(A_CTRL, 32'h4A);
        wait_wrap("R7 exponent 2", 12);
        wreg(A_CTRL, 32'h00);
        rreg(A_CNT, v); chk("R7 count", v, 32'd0);
    endtask

    task automatic t_source();
        logic [31:0] v;
        wreg(A_CNT, 32'd0);
        wreg(A_CTRL, 32'h10); idle(10);
        rreg(A_CNT, v); chk("R8 source 2 holds", v, 32'd0);
        wreg(A_CTRL, 32'h18); idle(10);
        rreg(A_CNT, v); chk("R8 source 3 holds", v, 32'd0);
        wreg(A_CTRL, 32'h00);
        chk("R10 ie off", {31'd0, irq}, 32'd0);
        rreg(A_CTRL, v); chk("R10 flag still set", v, 32'h80);
        wreg(A_CTRL, 32'h40);
        rreg(A_CTRL, v); chk("R9 armed clear", v, 32'h40);
    endtask

    task automatic t_unused();
        logic [31:0] v;
        wreg(8'h20, 32'hFFFF_FFFF);
        rreg(8'h20, v); chk("R11 undefined read", v, 32'h0);
        rreg(A_LIM, v); chk("R11 limit untouched", v, 32'd2);
        wreg(A_CTRL, 32'hFFFF_FF20);
        rreg(A_CTRL, v); chk("R11 unused ctrl bits", v, 32'h0);
        wreg(A_LIM, 32'hABCD_1234);
        rreg(A_LIM, v); chk("R11 truncation", v, 32'h1234);
    endtask

    task automatic t_top();
        logic [31:0] v;
        wreg(A_INIT, 32'hFFFD); wreg(A_LIM, 32'hFFFF); idle(2);
        wreg(A_CNT, 32'd0);
        rreg(A_CNT, v); chk("R3 start near top", v, 32'hFFFD);
        wreg(A_CTRL, 32'h48);
        wait_wrap("R3 top wrap", 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_shadow();
        t_prescale();
        t_source();
        t_unused();
        t_top();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule